// File: doc/BRIEF.md
# Multiported Shared VLIW Register File

This block is the architectural register file shared by all issue lanes of a very-long-instruction-word core. It has 32 registers of 32 bits. Each of the four lanes reads two source operands and writes one result in every cycle, so the file has eight combinational read ports and four synchronous write ports. Each read port selects from every register through a full multiplexer. Each register takes its next value through its own multiplexer over the lanes' write data, steered by a per-register write select.

Next to the lane ports, a wide side port serves an attached combinational accelerator. The accelerator reads the whole file at once. When both its run and commit strobes are high, it writes up to sixteen results back in a single cycle. The destination of each result comes from a fixed table of register indices with per-entry enables. Software places the accelerator's operands in ordinary registers, and its results land in ordinary registers, so a call to the accelerator costs no transfer. Register 0 is hard zero. A parameter adds forwarding of same-cycle writes to the read ports.

Top module: `vliw_regfile`

## Requirements
- R1: While the active-low reset is asserted, every register reads 0, and the reset takes effect without waiting for a clock edge.
- R2: Register 0 always reads 0. Lane writes to it and accelerator writes mapped to it have no effect.
- R3: When `wr_en[l]` is 1 at a rising edge, `wr_data[l]` is stored at `wr_addr[l]`. Each of the eight read ports returns the register at its own `rd_addr`, combinationally and independently of the other ports.
- R4: When several lanes write the same register in one cycle, the lane with the highest index wins.
- R5: `acc_rd_data[r]` presents register r for all 32 registers at the same time.
- R6: When `acc_run` and `acc_commit` are both 1 at a rising edge, every enabled map entry k stores `acc_wr_data[k]` into its destination register. The default map sends entries 0 to 13 to registers 16 to 29 and entry 14 to register 0. Entry 15 points at register 31 and is disabled.
- R7: An accelerator commit has no effect unless `acc_run` and `acc_commit` are both 1.
- R8: When a lane write and an accelerator write target the same register in one cycle, the lane write wins.
- R9: A register that no write in a cycle targets keeps its value.
- R10: With `FORWARD` at 0, a read in the same cycle as a write to that register returns the old value. With `FORWARD` at 1, it returns the value that wins under R4 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 2*NUM_LANES x ADDR_W | Register index for each read port; lane l owns ports 2l and 2l+1 |
| rd_data | output | 2*NUM_LANES x DATA_W | Value returned on each read port |
| wr_en | input | NUM_LANES | Write enable for each lane |
| wr_addr | input | NUM_LANES x ADDR_W | Destination register for each lane |
| wr_data | input | NUM_LANES x DATA_W | Result data for each lane |
| acc_run | input | 1 | The accelerator call is active |
| acc_commit | input | 1 | Write the accelerator results back this cycle |
| acc_wr_data | input | ACC_WR x DATA_W | Accelerator results, one per map entry |
| acc_rd_data | output | NUM_REGS x DATA_W | Every register, for the accelerator's operands |

## Verification
A table of lane writes tries a single lane, two lanes on one register, all four lanes on one register, a write to register 0, and two lanes writing disjoint registers. These patterns separate correct lane priority from last-writer or lowest-lane behaviour, and they expose a zero register that can be written. A read on all eight ports at once, each with a different address, shows whether the ports decode independently. The accelerator side is tried with run and commit together, with commit alone, with run alone, and with a lane write colliding on one destination. These cases separate correct gating and priority from a commit that fires early or wins the collision. Two instances that differ only in forwarding get the same colliding write with a same-cycle read, which tells old-value reads from forwarded winner reads.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
   localparam int unsigned DEF_LANES   = 4;
   localparam int unsigned DEF_REGS    = 32;
   localparam int unsigned DEF_WIDTH   = 32;
   localparam int unsigned DEF_ACC_WR  = 16;
   // width of one destination index inside the accelerator map parameter
   localparam int unsigned MAP_FIELD_W = 8;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/vrf_write_select.sv
// Per-register write steering: lanes by index priority, then accelerator map.
module vrf_write_select #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned REGS   = 32,
   parameter int unsigned DW     = 32,
   parameter int unsigned AW     = 5,
   parameter int unsigned ACC_WR = 16,
   parameter logic [ACC_WR*vrf_pkg::MAP_FIELD_W-1:0] ACC_DST = '0,
   parameter logic [ACC_WR-1:0] ACC_EN = '0
) (
   input  logic [LANES-1:0]           wr_en,
   input  logic [LANES-1:0][AW-1:0]   wr_addr,
   input  logic [LANES-1:0][DW-1:0]   wr_data,
   input  logic                       acc_fire,
   input  logic [ACC_WR-1:0][DW-1:0]  acc_wr_data,
   output logic [REGS-1:0]            reg_we,
   output logic [REGS-1:0][DW-1:0]    reg_wd
);
   localparam int unsigned FW = vrf_pkg::MAP_FIELD_W;

   for (genvar r = 0; r < REGS; r++) begin : g_reg
      if (r == 0) begin : g_zero
         assign reg_we[r] = 1'b0;
         assign reg_wd[r] = '0;
      end else begin : g_live
         logic          lane_hit;
         logic          acc_hit;
         logic [DW-1:0] lane_val;
         logic [DW-1:0] acc_val;

         // P:1 lane multiplexer, higher lane index overrides lower
         always_comb begin
            lane_hit = 1'b0;
            lane_val = '0;
            for (int l = 0; l < LANES; l++) begin
               if (wr_en[l] && (wr_addr[l] == AW'(r))) begin
                  lane_hit = 1'b1;
                  lane_val = wr_data[l];
               end
            end
         end

         // accelerator map lookup, higher entry overrides lower
         always_comb begin
            acc_hit = 1'b0;
            acc_val = '0;
            for (int k = 0; k < ACC_WR; k++) begin
               if (acc_fire && ACC_EN[k] &&
                   (ACC_DST[k*FW +: FW] == FW'(r))) begin
                  acc_hit = 1'b1;
                  acc_val = acc_wr_data[k];
               end
            end
         end

         assign reg_we[r] = lane_hit | acc_hit;
         assign reg_wd[r] = lane_hit ? lane_val : acc_val;
      end
   end
endmodule

// File: rtl/vrf_storage.sv
module vrf_storage #(
   parameter int unsigned REGS = 32,
   parameter int unsigned DW   = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [REGS-1:0]         reg_we,
   input  logic [REGS-1:0][DW-1:0] reg_wd,
   output logic [REGS-1:0][DW-1:0] regs
);
   for (genvar r = 0; r < REGS; r++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[r] <= '0;
         else if (reg_we[r])
            regs[r] <= reg_wd[r];
      end
   end
endmodule

// File: rtl/vrf_read_port.sv
// One R:1 read multiplexer over the whole file.
module vrf_read_port #(
   parameter int unsigned REGS = 32,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 5
) (
   input  logic [AW-1:0]           addr,
   input  logic [REGS-1:0][DW-1:0] view,
   output logic [DW-1:0]           data
);
   assign data = view[addr];
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
   parameter int unsigned NUM_LANES = vrf_pkg::DEF_LANES,
   parameter int unsigned NUM_REGS  = vrf_pkg::DEF_REGS,
   parameter int unsigned DATA_W    = vrf_pkg::DEF_WIDTH,
   parameter int unsigned ACC_WR    = vrf_pkg::DEF_ACC_WR,
   // destination index per accelerator result, one byte each, entry 0 lowest
   parameter logic [ACC_WR*vrf_pkg::MAP_FIELD_W-1:0] ACC_DST =
      128'h1F00_1D1C_1B1A_1918_1716_1514_1312_1110,
   parameter logic [ACC_WR-1:0] ACC_EN = 16'h7FFF,
   parameter bit FORWARD = 1'b0,
   localparam int unsigned ADDR_W   = vrf_pkg::idx_w(NUM_REGS),
   localparam int unsigned RD_PORTS = 2 * NUM_LANES
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [RD_PORTS-1:0][ADDR_W-1:0]   rd_addr,
   output logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data,
   input  logic [NUM_LANES-1:0]              wr_en,
   input  logic [NUM_LANES-1:0][ADDR_W-1:0]  wr_addr,
   input  logic [NUM_LANES-1:0][DATA_W-1:0]  wr_data,
   input  logic                              acc_run,
   input  logic                              acc_commit,
   input  logic [ACC_WR-1:0][DATA_W-1:0]     acc_wr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]   acc_rd_data
);
   localparam int unsigned FW = vrf_pkg::MAP_FIELD_W;

   // elaboration-time parameter checks
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("vliw_regfile: NUM_LANES must be at least 1");
   end
   if ((NUM_REGS < 2) || (NUM_REGS != (1 << ADDR_W))) begin : g_bad_regs
      $error("vliw_regfile: NUM_REGS must be a power of two, at least 2");
   end
   if ((ACC_WR < 1) || (ACC_WR > NUM_REGS)) begin : g_bad_accwr
      $error("vliw_regfile: ACC_WR must lie in 1..NUM_REGS");
   end
   if (NUM_REGS > (1 << FW)) begin : g_bad_field
      $error("vliw_regfile: NUM_REGS exceeds the map index field");
   end
   for (genvar k = 0; k < ACC_WR; k++) begin : g_map_chk
      if (ACC_DST[k*FW +: FW] >= NUM_REGS) begin : g_bad_dst
         $error("vliw_regfile: accelerator map entry out of range");
      end
   end

   logic                            acc_fire;
   logic [NUM_REGS-1:0]             reg_we;
   logic [NUM_REGS-1:0][DATA_W-1:0] reg_wd;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic [NUM_REGS-1:0][DATA_W-1:0] view;

   assign acc_fire = acc_run & acc_commit;

   vrf_write_select #(
      .LANES(NUM_LANES), .REGS(NUM_REGS), .DW(DATA_W), .AW(ADDR_W),
      .ACC_WR(ACC_WR), .ACC_DST(ACC_DST), .ACC_EN(ACC_EN)
   ) u_wsel (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .acc_fire(acc_fire), .acc_wr_data(acc_wr_data),
      .reg_we(reg_we), .reg_wd(reg_wd)
   );

   vrf_storage #(.REGS(NUM_REGS), .DW(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wd(reg_wd), .regs(regs)
   );

   // the read view either shows stored state or the pending winner
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_view
      if (FORWARD) begin : g_fwd
         assign view[r] = reg_we[r] ? reg_wd[r] : regs[r];
      end else begin : g_plain
         assign view[r] = regs[r];
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      vrf_read_port #(.REGS(NUM_REGS), .DW(DATA_W), .AW(ADDR_W)) u_rp (
         .addr(rd_addr[p]), .view(view), .data(rd_data[p])
      );
   end

   assign acc_rd_data = regs;
endmodule

// File: rtl/vrf_chk.sv
module vrf_chk #(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned NUM_REGS  = 32,
   parameter int unsigned DATA_W    = 32,
   parameter bit          FORWARD   = 1'b0
) (
   input logic                                                       clk,
   input logic                                                       rst_n,
   input logic [2*NUM_LANES-1:0][vrf_pkg::idx_w(NUM_REGS)-1:0]       rd_addr,
   input logic [2*NUM_LANES-1:0][DATA_W-1:0]                         rd_data,
   input logic [NUM_LANES-1:0]                                       wr_en,
   input logic [NUM_LANES-1:0][vrf_pkg::idx_w(NUM_REGS)-1:0]         wr_addr,
   input logic [NUM_LANES-1:0][DATA_W-1:0]                           wr_data,
   input logic                                                       acc_run,
   input logic                                                       acc_commit,
   input logic [NUM_REGS-1:0][DATA_W-1:0]                            acc_rd_data
);
   localparam int unsigned AW = vrf_pkg::idx_w(NUM_REGS);
   localparam int unsigned TL = NUM_LANES - 1;

   logic [NUM_REGS-1:0] lane_hit;
   always_comb begin
      lane_hit = '0;
      for (int r = 0; r < NUM_REGS; r++)
         for (int l = 0; l < NUM_LANES; l++)
            if (wr_en[l] && (wr_addr[l] == AW'(r))) lane_hit[r] = 1'b1;
   end

   // R2: register 0 stays zero in storage
   p_zero_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd_data[0] == '0);

   for (genvar p = 0; p < 2*NUM_LANES; p++) begin : g_port
      // R2: any port reading register 0 returns zero
      p_zero_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_addr[p] == '0) |-> (rd_data[p] == '0));
      if (FORWARD == 1'b0) begin : g_nofwd
         // R10: without forwarding a port returns stored state
         p_no_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[p] == acc_rd_data[rd_addr[p]]);
      end
   end

   // R4: the highest lane always lands its write
   p_top_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[TL] && (wr_addr[TL] != '0)) |=>
      (acc_rd_data[$past(wr_addr[TL])] == $past(wr_data[TL])));

   // R8: a lane write beats an accelerator commit
   p_lane_over_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_run && acc_commit && wr_en[TL] && (wr_addr[TL] != '0)) |=>
      (acc_rd_data[$past(wr_addr[TL])] == $past(wr_data[TL])));

   // R7: commit without run changes nothing
   p_idle_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_commit && !acc_run && (wr_en == '0)) |=> $stable(acc_rd_data));

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_hold
      // R9: untargeted registers hold
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (!lane_hit[r] && !(acc_run && acc_commit)) |=> $stable(acc_rd_data[r]));
   end
endmodule

bind vliw_regfile vrf_chk #(
   .NUM_LANES(NUM_LANES), .NUM_REGS(NUM_REGS),
   .DATA_W(DATA_W), .FORWARD(FORWARD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .acc_run(acc_run), .acc_commit(acc_commit), .acc_rd_data(acc_rd_data)
);

// File: tb/vliw_regfile_tb_top.sv
module vliw_regfile_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic                   rst_n;
   logic [7:0][4:0]        rd_addr;
   logic [7:0][31:0]       rd_data, rd_data_f;
   logic [3:0]             wr_en;
   logic [3:0][4:0]        wr_addr;
   logic [3:0][31:0]       wr_data;
   logic                   acc_run, acc_commit;
   logic [15:0][31:0]      acc_wr_data;
   logic [31:0][31:0]      acc_rd, acc_rd_f;

   vliw_regfile #(.FORWARD(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .acc_run(acc_run), .acc_commit(acc_commit),
      .acc_wr_data(acc_wr_data), .acc_rd_data(acc_rd));

   vliw_regfile #(.FORWARD(1'b1)) dut_fwd_i (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data_f),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .acc_run(acc_run), .acc_commit(acc_commit),
      .acc_wr_data(acc_wr_data), .acc_rd_data(acc_rd_f));

   int nchk = 0, nfail = 0;
   bit done = 1'b0;
   logic [31:0] mdl [32];

   typedef struct packed {
      logic [3:0]       we;
      logic [3:0][4:0]  wa;
      logic [3:0][31:0] wd;
      logic [2:0]       rp;
      logic [4:0]       ra;
      logic [31:0]      exp;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{we:4'b0001, wa:{5'd0,5'd0,5'd0,5'd1},
        wd:{32'h0,32'h0,32'h0,32'h11111111}, rp:3'd0, ra:5'd1, exp:32'h11111111},
      '{we:4'b0101, wa:{5'd0,5'd5,5'd0,5'd5},
        wd:{32'h0,32'hA2A2A2A2,32'h0,32'hA0A0A0A0}, rp:3'd3, ra:5'd5, exp:32'hA2A2A2A2},
      '{we:4'b1111, wa:{5'd7,5'd7,5'd7,5'd7},
        wd:{32'h73737373,32'h72727272,32'h71717171,32'h70707070}, rp:3'd7, ra:5'd7, exp:32'h73737373},
      '{we:4'b0100, wa:{5'd0,5'd0,5'd0,5'd0},
        wd:{32'h0,32'hFFFFFFFF,32'h0,32'h0}, rp:3'd2, ra:5'd0, exp:32'h0},
      '{we:4'b1010, wa:{5'd31,5'd0,5'd9,5'd0},
        wd:{32'h31313131,32'h0,32'h09090909,32'h0}, rp:3'd5, ra:5'd9, exp:32'h09090909},
      '{we:4'b0011, wa:{5'd0,5'd0,5'd3,5'd3},
        wd:{32'h0,32'h0,32'h13131313,32'h03030303}, rp:3'd1, ra:5'd3, exp:32'h13131313}
   };
   localparam string VTAG [NV] = '{"R3", "R4", "R4", "R2", "R3", "R4"};

   // accelerator map as stated in R6
   function automatic int map_dst(input int k);
      return (k < 14) ? 16 + k : ((k == 14) ? 0 : 31);
   endfunction
   function automatic bit map_en(input int k);
      return k != 15;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_in();
      wr_en = '0; wr_addr = '0; wr_data = '0;
      acc_run = 1'b0; acc_commit = 1'b0;
   endtask

   task automatic model_reset();
      for (int r = 0; r < 32; r++) mdl[r] = '0;
   endtask

   // apply the driven inputs for one edge, updating the model per R4/R6/R8
   task automatic tick();
      if (acc_run && acc_commit)
         for (int k = 0; k < 16; k++)
            if (map_en(k) && map_dst(k) != 0) mdl[map_dst(k)] = acc_wr_data[k];
      for (int l = 0; l < 4; l++)
         if (wr_en[l] && wr_addr[l] != 0) mdl[wr_addr[l]] = wr_data[l];
      @(posedge clk); #1;
      clear_in();
      #2;
   endtask

   task automatic check_all(input string tag);
      for (int r = 0; r < 32; r++) begin
         check(tag, acc_rd[r], mdl[r]);
         check(tag, acc_rd_f[r], mdl[r]);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; rd_addr = '0; acc_wr_data = '0;
      clear_in(); model_reset();
      repeat (3) @(posedge clk); #1;
      check_all("R1 during reset");
      rst_n = 1'b1;
      @(posedge clk); #3;
      check_all("R1 after reset");

      // table of lane write patterns
      for (int v = 0; v < NV; v++) begin
         wr_en = VECS[v].we; wr_addr = VECS[v].wa; wr_data = VECS[v].wd;
         tick();
         rd_addr = '0;
         rd_addr[VECS[v].rp] = VECS[v].ra;
         #2;
         check(VTAG[v], rd_data[VECS[v].rp], VECS[v].exp);
         check(VTAG[v], rd_data_f[VECS[v].rp], VECS[v].exp);
      end

      // R3: all eight ports at once, distinct addresses
      rd_addr = {5'd2, 5'd3, 5'd31, 5'd9, 5'd0, 5'd7, 5'd5, 5'd1};
      #2;
      for (int p = 0; p < 8; p++) check("R3 parallel ports", rd_data[p], mdl[rd_addr[p]]);
      check_all("R5 full view");

      // R10: same-cycle read of a colliding write
      @(posedge clk); #1;
      rd_addr = '0; rd_addr[4] = 5'd12;
      wr_en = 4'b0110;
      wr_addr[1] = 5'd12; wr_data[1] = 32'h11110000;
      wr_addr[2] = 5'd12; wr_data[2] = 32'h12121212;
      #2;
      check("R10 no forward old value", rd_data[4], 32'h0);
      check("R10 forward winner", rd_data_f[4], 32'h12121212);
      tick();
      check("R10 after edge", rd_data[4], 32'h12121212);
      check("R10 after edge fwd", rd_data_f[4], 32'h12121212);

      // R6: accelerator commit through the default map
      for (int k = 0; k < 16; k++) acc_wr_data[k] = 32'hC0DE0000 + k;
      acc_run = 1'b1; acc_commit = 1'b1;
      tick();
      check("R6 entry0", acc_rd[16], 32'hC0DE0000);
      check("R6 entry13", acc_rd[29], 32'hC0DE000D);
      check("R6 disabled entry15", acc_rd[31], 32'h31313131);
      check("R2 map to reg0", acc_rd[0], 32'h0);
      check_all("R6 view");

      // R7: commit without run, then run without commit
      for (int k = 0; k < 16; k++) acc_wr_data[k] = 32'hDEAD0000 + k;
      acc_commit = 1'b1;
      tick();
      check("R7 commit alone", acc_rd[16], 32'hC0DE0000);
      acc_run = 1'b1;
      tick();
      check("R7 run alone", acc_rd[17], 32'hC0DE0001);
      check_all("R7 view");

      // R8: lane write collides with accelerator destination
      for (int k = 0; k < 16; k++) acc_wr_data[k] = 32'hF00D0000 + k;
      acc_run = 1'b1; acc_commit = 1'b1;
      wr_en = 4'b0010; wr_addr[1] = 5'd20; wr_data[1] = 32'hBEEFBEEF;
      tick();
      check("R8 lane wins", acc_rd[20], 32'hBEEFBEEF);
      check("R8 neighbour from accel", acc_rd[21], 32'hF00D0005);

      // R9: untouched registers kept their values
      check("R9 reg1 held", acc_rd[1], 32'h11111111);
      check("R9 reg9 held", acc_rd[9], 32'h09090909);
      check("R9 reg30 held", acc_rd[30], 32'h0);

      // R1: asynchronous reset mid-run
      @(posedge clk); #5;
      rst_n = 1'b0;
      model_reset();
      #2;
      check_all("R1 async reset");
      @(posedge clk); #1;
      rst_n = 1'b1;
      #2;

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule